// File: doc/BRIEF.md
# I2C Target Register and FIFO Front End

This block is the software-visible side of an I2C target. It holds one 32-bit control/status word and one byte-wide data port. Behind the data port are two byte queues of power-of-two depth. The transmit queue is filled by software and drained by the bus engine. The receive queue is filled by the engine and drained by software. The block hands the engine its configuration (enable, filter rate, 7-bit own address), the transmit head byte and the gated push/pop strobes. It also raises one level interrupt built from the enabled queue conditions.

Software uses a simple register strobe interface. `regAddr` 0 selects the control word and `regAddr` 1 selects the data port. A write counts only when `regWrFull` marks it as a full 32-bit access. Read data is combinational from the current state. A data-port read pops the receive queue at the clock edge that ends the read cycle.

Top module: `i2c_target_csr`

## Requirements
- R1: After reset, the control readback is 0x68010000 with the default depth of 4 and both sense inputs high, `irq` is 0, every configuration output is 0 and `engTxData` is 0xFF.
- R2: A full-width control write stores enable (bit 0), filter select (bit 3), own address (bits 10:4), and the interrupt enables for RX-available (bit 11), RX-full (bit 12) and TX-empty (bit 13). These fields read back unchanged and drive `cfgEnable`, `cfgFilterSel` and `cfgDevAddr`. Bits 1 and 2 always read as 0.
- R3: Control readback bits 18:15 hold log2 of the queue depth, bit 25 is RX available, bit 26 RX full, bit 27 TX empty, bit 28 TX full, bit 29 the sensed clock line, bit 30 the sensed data line and bit 31 busy. All other unlisted bits read as 0.
- R4: A full-width data write (bits 7:0) appends to the TX queue. `engTxData` shows the oldest byte and each `engTxPop` advances it in write order. When the TX queue is empty, `engTxData` is 0xFF.
- R5: `engRxPush` appends `engRxData` to the RX queue, and a data read returns the oldest byte in bits 7:0 and removes it. A data read while the RX queue is empty returns 0 and leaves the queue unchanged.
- R6: A data write while the TX queue is full is dropped, and an engine push while the RX queue is full is dropped. The stored bytes are kept.
- R7: Writing 1 to control bit 1 empties only the RX queue, and writing 1 to bit 2 empties only the TX queue. Neither bit is stored.
- R8: While enable is 0, both queues are held empty, and data writes and engine pushes have no effect.
- R9: A write with `regWrFull` low changes neither register nor any queue.
- R10: `irq` is the OR of the enabled conditions among RX-available, RX-full and TX-empty. It stays high while any enabled condition holds, and it is 0 whenever enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 1 | 0 = control word, 1 = data port |
| regWrData | input | 32 | Write data |
| regWrFull | input | 1 | Write is a full 32-bit access |
| regRdData | output | 32 | Read data (combinational) |
| engRxPush | input | 1 | Engine pushes a received byte |
| engRxData | input | 8 | Byte received by the engine |
| engTxPop | input | 1 | Engine consumes the TX head byte |
| engTxData | output | 8 | TX head byte, 0xFF when empty |
| engBusy | input | 1 | Engine transaction in progress |
| senseScl | input | 1 | Sensed clock line level |
| senseSda | input | 1 | Sensed data line level |
| cfgEnable | output | 1 | Module enable to engine |
| cfgFilterSel | output | 1 | Sample-rate / filter select |
| cfgDevAddr | output | 7 | Own 7-bit address |
| irq | output | 1 | Level interrupt |

## Verification
The queues are tested with three patterns:
- A short burst that stays below the depth, which shows ordering and the head byte.
- A burst one longer than the depth, which separates a dropped overflow byte from an overwrite.
- Reads and pops past empty, which separate a harmless underflow from one that corrupts the pointers.

Each clear bit is applied with both queues holding data, so that a clear reaching the wrong queue shows up. The disable path is tried with writes and pushes issued while disabled. Interrupt enables are switched one at a time against states where the condition does and does not hold. This separates a missing OR term, a wrong polarity and a missing enable gate.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_DATA = 1'b1;

  // control word bit positions
  localparam int B_EN      = 0;
  localparam int B_CLR_RX  = 1;
  localparam int B_CLR_TX  = 2;
  localparam int B_FSEL    = 3;
  localparam int B_ADDR_LO = 4;
  localparam int B_IE_RXA  = 11;
  localparam int B_IE_RXF  = 12;
  localparam int B_IE_TXE  = 13;
  localparam int B_DLOG_LO = 15;
  localparam int B_RXA     = 25;
  localparam int B_RXF     = 26;
  localparam int B_TXE     = 27;
  localparam int B_TXF     = 28;
  localparam int B_SCL     = 29;
  localparam int B_SDA     = 30;
  localparam int B_BUSY    = 31;

  typedef struct packed {
    logic push;
    logic pop;
    logic clr;
  } fifoStrb_t;

  typedef struct packed {
    fifoStrb_t rx;
    fifoStrb_t tx;
  } fifoCtl_t;

  typedef struct packed {
    logic rxAvail;
    logic rxFull;
    logic txEmpty;
    logic txFull;
  } fifoStat_t;

  typedef struct packed {
    logic       ieTxEmpty;
    logic       ieRxFull;
    logic       ieRxAvail;
    logic [6:0] devAddr;
    logic       filterSel;
    logic       enable;
  } ctrlReg_t;

endpackage

// File: rtl/i2c_tgt_fifo.sv
module i2c_tgt_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);

  generate
    if (DEPTH == 1) begin : gHold
      logic             validQ;
      logic [WIDTH-1:0] dataQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          validQ <= 1'b0;
          dataQ  <= '0;
        end else if (clr) begin
          validQ <= 1'b0;
        end else begin
          if (pop && validQ) validQ <= 1'b0;
          if (push && !validQ) begin
            validQ <= 1'b1;
            dataQ  <= pushData;
          end
        end
      end

      assign head  = dataQ;
      assign empty = !validQ;
      assign full  = validQ;
    end else begin : gRing
      localparam int AW = $clog2(DEPTH);
      localparam logic [AW:0] CNT_MAX = (AW+1)'(DEPTH);

      logic [WIDTH-1:0] mem [DEPTH];
      logic [AW-1:0]    wrPtr, rdPtr;
      logic [AW:0]      cnt;
      logic             doPush, doPop;

      assign empty  = (cnt == '0);
      assign full   = (cnt == CNT_MAX);
      assign doPush = push && !full;
      assign doPop  = pop && !empty;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          wrPtr <= '0;
          rdPtr <= '0;
          cnt   <= '0;
        end else if (clr) begin
          wrPtr <= '0;
          rdPtr <= '0;
          cnt   <= '0;
        end else begin
          if (doPush) wrPtr <= wrPtr + 1'b1;
          if (doPop)  rdPtr <= rdPtr + 1'b1;
          case ({doPush, doPop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
          endcase
        end
      end

      always_ff @(posedge clk) begin
        if (doPush && !clr) mem[wrPtr] <= pushData;
      end

      assign head = mem[rdPtr];
    end
  endgenerate

endmodule

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  fifoCtl_t  ctl,
  input  logic [7:0] txWrData,
  input  logic [7:0] rxPushData,
  output logic [7:0] rxHead,
  output logic [7:0] txHead,
  output fifoStat_t stat
);

  logic rxEmpty, rxFull, txEmpty, txFull;

  i2c_tgt_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) rxFifo_i (
    .clk(clk), .rstN(rstN), .clr(ctl.rx.clr),
    .push(ctl.rx.push), .pushData(rxPushData), .pop(ctl.rx.pop),
    .head(rxHead), .empty(rxEmpty), .full(rxFull)
  );

  i2c_tgt_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) txFifo_i (
    .clk(clk), .rstN(rstN), .clr(ctl.tx.clr),
    .push(ctl.tx.push), .pushData(txWrData), .pop(ctl.tx.pop),
    .head(txHead), .empty(txEmpty), .full(txFull)
  );

  assign stat.rxAvail = !rxEmpty;
  assign stat.rxFull  = rxFull;
  assign stat.txEmpty = txEmpty;
  assign stat.txFull  = txFull;

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  input  logic        regWrFull,
  output logic [31:0] regRdData,
  input  logic        engRxPush,
  input  logic        engTxPop,
  input  logic        engBusy,
  input  logic        senseScl,
  input  logic        senseSda,
  input  fifoStat_t   stat,
  input  logic [7:0]  rxHead,
  input  logic [7:0]  txHead,
  output logic [7:0]  engTxData,
  output fifoCtl_t    ctl,
  output ctrlReg_t    cfg,
  output logic        irq
);

  localparam logic [3:0] DEPTH_LOG = 4'($clog2(FIFO_DEPTH));

  ctrlReg_t cfgQ;
  logic     wrCtrl, wrData, rdData;

  assign wrCtrl = regWrEn && regWrFull && (regAddr == ADDR_CTRL);
  assign wrData = regWrEn && regWrFull && (regAddr == ADDR_DATA);
  assign rdData = regRdEn && (regAddr == ADDR_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (wrCtrl) begin
      cfgQ.enable    <= regWrData[B_EN];
      cfgQ.filterSel <= regWrData[B_FSEL];
      cfgQ.devAddr   <= regWrData[B_ADDR_LO +: 7];
      cfgQ.ieRxAvail <= regWrData[B_IE_RXA];
      cfgQ.ieRxFull  <= regWrData[B_IE_RXF];
      cfgQ.ieTxEmpty <= regWrData[B_IE_TXE];
    end
  end

  // strobes to the datapath; clear has priority inside the queues
  always_comb begin
    ctl.rx.clr  = !cfgQ.enable || (wrCtrl && regWrData[B_CLR_RX]);
    ctl.tx.clr  = !cfgQ.enable || (wrCtrl && regWrData[B_CLR_TX]);
    ctl.rx.push = cfgQ.enable && engRxPush;
    ctl.rx.pop  = cfgQ.enable && rdData;
    ctl.tx.push = cfgQ.enable && wrData;
    ctl.tx.pop  = cfgQ.enable && engTxPop;
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CTRL) begin
      regRdData[B_EN]            = cfgQ.enable;
      regRdData[B_FSEL]          = cfgQ.filterSel;
      regRdData[B_ADDR_LO +: 7]  = cfgQ.devAddr;
      regRdData[B_IE_RXA]        = cfgQ.ieRxAvail;
      regRdData[B_IE_RXF]        = cfgQ.ieRxFull;
      regRdData[B_IE_TXE]        = cfgQ.ieTxEmpty;
      regRdData[B_DLOG_LO +: 4]  = DEPTH_LOG;
      regRdData[B_RXA]           = stat.rxAvail;
      regRdData[B_RXF]           = stat.rxFull;
      regRdData[B_TXE]           = stat.txEmpty;
      regRdData[B_TXF]           = stat.txFull;
      regRdData[B_SCL]           = senseScl;
      regRdData[B_SDA]           = senseSda;
      regRdData[B_BUSY]          = engBusy;
    end else if (stat.rxAvail) begin
      regRdData[7:0] = rxHead;
    end
  end

  assign engTxData = stat.txEmpty ? 8'hFF : txHead;
  assign irq = cfgQ.enable && ((cfgQ.ieRxAvail && stat.rxAvail) ||
                               (cfgQ.ieRxFull  && stat.rxFull)  ||
                               (cfgQ.ieTxEmpty && stat.txEmpty));
  assign cfg = cfgQ;

endmodule

// File: rtl/i2c_target_csr.sv
module i2c_target_csr
  import i2c_tgt_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  input  logic        regWrFull,
  output logic [31:0] regRdData,
  input  logic        engRxPush,
  input  logic [7:0]  engRxData,
  input  logic        engTxPop,
  output logic [7:0]  engTxData,
  input  logic        engBusy,
  input  logic        senseScl,
  input  logic        senseSda,
  output logic        cfgEnable,
  output logic        cfgFilterSel,
  output logic [6:0]  cfgDevAddr,
  output logic        irq
);

  fifoCtl_t  fifoCtl;
  fifoStat_t fifoStat;
  ctrlReg_t  cfg;
  logic [7:0] rxHead, txHead;

  i2c_tgt_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regWrFull(regWrFull), .regRdData(regRdData),
    .engRxPush(engRxPush), .engTxPop(engTxPop), .engBusy(engBusy),
    .senseScl(senseScl), .senseSda(senseSda),
    .stat(fifoStat), .rxHead(rxHead), .txHead(txHead),
    .engTxData(engTxData), .ctl(fifoCtl), .cfg(cfg), .irq(irq)
  );

  i2c_tgt_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(fifoCtl),
    .txWrData(regWrData[7:0]), .rxPushData(engRxData),
    .rxHead(rxHead), .txHead(txHead), .stat(fifoStat)
  );

  assign cfgEnable    = cfg.enable;
  assign cfgFilterSel = cfg.filterSel;
  assign cfgDevAddr   = cfg.devAddr;

endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
  import i2c_tgt_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic        regAddr,
  input logic        regWrFull,
  input logic [31:0] regRdData,
  input logic        engTxPop,
  input logic [7:0]  engTxData,
  input logic        cfgEnable,
  input logic        cfgFilterSel,
  input logic [6:0]  cfgDevAddr,
  input logic        irq,
  input fifoStat_t   stat
);

  AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> (!stat.rxAvail && stat.txEmpty)); // R8

  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (stat.txFull && cfgEnable && regWrEn && regWrFull && regAddr == ADDR_DATA && !engTxPop)
    |=> (stat.txFull && $stable(engTxData))); // R6

  AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!stat.rxAvail && regRdEn && regAddr == ADDR_DATA) |-> (regRdData == 32'h0)); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> !irq); // R10

  AST_TX_EMPTY_ONES: assert property (@(posedge clk) disable iff (!rstN)
    stat.txEmpty |-> (engTxData == 8'hFF)); // R4

  AST_NARROW_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regWrFull) |=> $stable({cfgEnable, cfgFilterSel, cfgDevAddr})); // R9

  AST_FLAG_CONSIST: assert property (@(posedge clk) disable iff (!rstN)
    !(stat.rxFull && !stat.rxAvail) && !(stat.txFull && stat.txEmpty)); // R3

endmodule

bind i2c_target_csr i2c_tgt_checker chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .regWrFull(regWrFull), .regRdData(regRdData),
  .engTxPop(engTxPop), .engTxData(engTxData), .cfgEnable(cfgEnable),
  .cfgFilterSel(cfgFilterSel), .cfgDevAddr(cfgDevAddr), .irq(irq),
  .stat(fifoStat)
);

// File: tb/i2c_target_csr_tb_top.sv
module i2c_target_csr_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0, regAddr = 1'b0, regWrFull = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        engRxPush = 1'b0, engTxPop = 1'b0, engBusy = 1'b0;
  logic [7:0]  engRxData = '0;
  logic [7:0]  engTxData;
  logic        senseScl = 1'b1, senseSda = 1'b1;
  logic        cfgEnable, cfgFilterSel, irq;
  logic [6:0]  cfgDevAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  i2c_target_csr dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regWrFull(regWrFull),
    .regRdData(regRdData), .engRxPush(engRxPush), .engRxData(engRxData),
    .engTxPop(engTxPop), .engTxData(engTxData), .engBusy(engBusy),
    .senseScl(senseScl), .senseSda(senseSda), .cfgEnable(cfgEnable),
    .cfgFilterSel(cfgFilterSel), .cfgDevAddr(cfgDevAddr), .irq(irq)
  );

  localparam logic [31:0] EN  = 32'h1;
  localparam logic [31:0] CRX = 32'h2;
  localparam logic [31:0] CTX = 32'h4;
  localparam logic [31:0] IRA = 32'h800;
  localparam logic [31:0] IRF = 32'h1000;
  localparam logic [31:0] ITE = 32'h2000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic a, input logic [31:0] d, input logic full);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d; regWrFull = full;
    @(negedge clk);
    regWrEn = 1'b0; regWrFull = 1'b0;
  endtask

  task automatic regRead(input logic a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic engPush(input logic [7:0] b);
    @(negedge clk);
    engRxPush = 1'b1; engRxData = b;
    @(negedge clk);
    engRxPush = 1'b0;
  endtask

  task automatic engPop();
    @(negedge clk);
    engTxPop = 1'b1;
    @(negedge clk);
    engTxPop = 1'b0;
  endtask

  task automatic tReset();
    logic [31:0] d;
    regRead(1'b0, d);
    check("R1 reset ctrl", d, 32'h68010000);
    check("R1 reset irq", {31'b0, irq}, 32'h0);
    check("R1 reset cfg", {23'b0, cfgEnable, cfgFilterSel, cfgDevAddr}, 32'h0);
    check("R1 reset txdata", {24'b0, engTxData}, 32'hFF);
  endtask

  task automatic tConfig();
    logic [31:0] d;
    regWrite(1'b0, EN | 32'h8 | (32'h5A << 4) | CRX | CTX, 1'b1);
    regRead(1'b0, d);
    check("R2 ctrl readback", d, 32'h68010000 | 32'h5A9);
    check("R2 cfg outputs", {23'b0, cfgEnable, cfgFilterSel, cfgDevAddr}, {23'b0, 2'b11, 7'h5A});
    regWrite(1'b0, EN | IRA | IRF | ITE | (32'h33 << 4), 1'b1);
    regRead(1'b0, d);
    check("R2 ie bits readback", d & 32'h00003FFF, EN | IRA | IRF | ITE | (32'h33 << 4));
    regWrite(1'b0, EN, 1'b1);
  endtask

  task automatic tStatus();
    logic [31:0] d;
    engBusy = 1'b1; senseScl = 1'b0; senseSda = 1'b1;
    regRead(1'b0, d);
    check("R3 status bits", d & 32'hFFFF8000, 32'hC8010000);
    engBusy = 1'b0; senseScl = 1'b1; senseSda = 1'b0;
    regRead(1'b0, d);
    check("R3 sense swap", d & 32'hFFFF8000, 32'h28010000);
    senseSda = 1'b1;
  endtask

  task automatic tTx();
    logic [31:0] d;
    regWrite(1'b1, 32'hFFFFFF11, 1'b1);
    regWrite(1'b1, 32'h22, 1'b1);
    regWrite(1'b1, 32'h33, 1'b1);
    check("R4 head first", {24'b0, engTxData}, 32'h11);
    regRead(1'b0, d);
    check("R4 tx not empty", {31'b0, d[27]}, 32'h0);
    engPop();
    check("R4 head second", {24'b0, engTxData}, 32'h22);
    engPop();
    check("R4 head third", {24'b0, engTxData}, 32'h33);
    engPop();
    check("R4 empty ones", {24'b0, engTxData}, 32'hFF);
    engPop();
    check("R4 pop past empty", {24'b0, engTxData}, 32'hFF);
  endtask

  task automatic tRx();
    logic [31:0] d;
    engPush(8'hA1);
    engPush(8'hB2);
    regRead(1'b0, d);
    check("R5 rx avail", {31'b0, d[25]}, 32'h1);
    regRead(1'b1, d);
    check("R5 read first", d, 32'hA1);
    regRead(1'b1, d);
    check("R5 read second", d, 32'hB2);
    regRead(1'b1, d);
    check("R5 empty read zero", d, 32'h0);
    engPush(8'hC3);
    regRead(1'b1, d);
    check("R5 after underflow", d, 32'hC3);
  endtask

  task automatic tFull();
    logic [31:0] d;
    for (int i = 1; i <= 5; i++) regWrite(1'b1, 32'(i), 1'b1);
    regRead(1'b0, d);
    check("R6 tx full flag", {31'b0, d[28]}, 32'h1);
    for (int i = 1; i <= 4; i++) begin
      check("R6 tx kept order", {24'b0, engTxData}, 32'(i));
      engPop();
    end
    check("R6 tx overflow dropped", {24'b0, engTxData}, 32'hFF);
    for (int i = 0; i < 5; i++) engPush(8'h10 + 8'(i));
    regRead(1'b0, d);
    check("R6 rx full flag", {30'b0, d[26:25]}, 32'h3);
    for (int i = 0; i < 4; i++) begin
      regRead(1'b1, d);
      check("R6 rx kept order", d, 32'h10 + 32'(i));
    end
    regRead(1'b1, d);
    check("R6 rx overflow dropped", d, 32'h0);
  endtask

  task automatic tClear();
    logic [31:0] d;
    regWrite(1'b1, 32'h77, 1'b1);
    engPush(8'h66);
    regWrite(1'b0, EN | CRX, 1'b1);
    regRead(1'b0, d);
    check("R7 clr bits read zero", d & 32'h7, 32'h1);
    check("R7 rx cleared", {31'b0, d[25]}, 32'h0);
    check("R7 tx kept", {24'b0, engTxData}, 32'h77);
    engPush(8'h55);
    regWrite(1'b0, EN | CTX, 1'b1);
    check("R7 tx cleared", {24'b0, engTxData}, 32'hFF);
    regRead(1'b1, d);
    check("R7 rx kept", d, 32'h55);
  endtask

  task automatic tDisable();
    logic [31:0] d;
    regWrite(1'b1, 32'h44, 1'b1);
    engPush(8'h45);
    regWrite(1'b0, 32'h0, 1'b1);
    regWrite(1'b1, 32'h99, 1'b1);
    engPush(8'h98);
    regWrite(1'b0, EN, 1'b1);
    check("R8 tx flushed", {24'b0, engTxData}, 32'hFF);
    regRead(1'b1, d);
    check("R8 rx flushed", d, 32'h0);
  endtask

  task automatic tNarrow();
    logic [31:0] d;
    regWrite(1'b0, EN | (32'h21 << 4), 1'b1);
    regWrite(1'b1, 32'h55, 1'b0);
    check("R9 narrow data ignored", {24'b0, engTxData}, 32'hFF);
    regWrite(1'b0, EN | 32'h8 | (32'h7F << 4) | ITE, 1'b0);
    regRead(1'b0, d);
    check("R9 narrow ctrl ignored", d & 32'h3FFF, EN | (32'h21 << 4));
  endtask

  task automatic tIrq();
    regWrite(1'b0, EN | ITE, 1'b1);
    check("R10 tx empty irq", {31'b0, irq}, 32'h1);
    regWrite(1'b1, 32'h12, 1'b1);
    check("R10 tx nonempty no irq", {31'b0, irq}, 32'h0);
    engPop();
    check("R10 tx empty again", {31'b0, irq}, 32'h1);
    regWrite(1'b0, EN | IRA, 1'b1);
    check("R10 rxavail idle", {31'b0, irq}, 32'h0);
    engPush(8'h01);
    engPush(8'h02);
    check("R10 rxavail irq", {31'b0, irq}, 32'h1);
    regRead(1'b1, regWrData);
    check("R10 irq held", {31'b0, irq}, 32'h1);
    regRead(1'b1, regWrData);
    check("R10 irq released", {31'b0, irq}, 32'h0);
    regWrite(1'b0, EN | IRF, 1'b1);
    for (int i = 0; i < 3; i++) engPush(8'(i));
    check("R10 rxfull not yet", {31'b0, irq}, 32'h0);
    engPush(8'h03);
    check("R10 rxfull irq", {31'b0, irq}, 32'h1);
    regWrite(1'b0, IRA | IRF | ITE, 1'b1);
    check("R10 disabled no irq", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tConfig();
    tStatus();
    tTx();
    tRx();
    tFull();
    tClear();
    tDisable();
    tNarrow();
    tIrq();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule